// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with Thresholds

This block holds the word buffers that sit between a serial peripheral interface shifter and the system side. It has one transmit queue, which software fills and the shifter drains, and one receive queue, which the shifter fills and software drains. A single 32-bit control word, written through a simple register port, programs the following:

- a 3-bit watermark for each queue;
- pointer-only clear pulses;
- reset pulses that also clear the error flags;
- the interrupt enables.

Each queue reports its entry count, full and empty flags, a watermark flag, and a sticky error flag. The transmit queue records underflow and the receive queue records overflow.

A data-length input selects the word size in bits. Words of 16 bits or less use all eight storage slots and the full 3-bit watermark. Longer words halve the usable depth to four and drop the watermark's top bit. The transmit watermark flag reports "few enough entries" (count at or below the watermark). The receive flag reports "enough entries" (count above the watermark). Each queue's popped word is held in an output register. Clearing a queue leaves that register untouched.

Top module: `spi_fifo_pair`

## Requirements
- R1: After synchronous reset the control word reads 0x2200_0000 (both watermarks 2, everything else 0). Both counts are 0, both queues are empty and not full, and both error flags are 0.
- R2: Words leave each queue in push order. A pop of a non-empty queue updates that queue's pop-data output at the next clock edge. The count follows accepted pushes and pops, and a simultaneous push and pop leaves it unchanged.
- R3: The usable depth is 8 when data_len ≤ 16 and 4 when data_len > 16. Full is 1 while count ≥ the usable depth, and a push while full is dropped.
- R4: tx_thresh is 1 exactly when tx_count ≤ the effective transmit watermark (control bits [30:28]). It follows the count and the watermark combinationally.
- R5: rx_thresh is 1 exactly when rx_count > the effective receive watermark (control bits [26:24]). It follows the count and the watermark combinationally.
- R6: When data_len > 16 the top watermark bit is ignored, so the effective watermark is its lower two bits. Otherwise all three bits count.
- R7: Writing 1 to control bit 9 (transmit) or bit 8 (receive) empties that queue at the same edge: count 0, empty 1, full 0. Any push or pop to that queue in that cycle is ignored. The bit reads 1 for one cycle and then returns to 0 by itself.
- R8: A pointer-only clear changes neither the pop-data output nor the error flag of that queue.
- R9: A push to a full receive queue is dropped, leaves the stored words intact, and sets the sticky rx_overflow flag.
- R10: A pop of an empty transmit queue leaves tx_pop_data at its previous value and sets the sticky tx_underflow flag.
- R11: Writing 1 to control bit 1 (transmit) or bit 0 (receive) empties that queue and clears its error flag at the same edge. The bit self-clears after one cycle.
- R12: The interrupt outputs are the error, timeout and watermark conditions gated by enable bits: transmit underflow by bit 7, receive overflow by bit 5, receive timeout by bit 4, transmit watermark by bit 3, receive watermark by bit 2.
- R13: Control bits 31, 27, 23:10 and 6 are reserved. They read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write value |
| cfg_rd_data | output | 32 | Current control word |
| data_len | input | 6 | Serial word length in bits (8..32) |
| rx_timeout | input | 1 | Receive timeout condition from the shifter side |
| tx_push | input | 1 | Push a word into the transmit queue |
| tx_push_data | input | 32 | Word to push into the transmit queue |
| tx_pop | input | 1 | Pop a word from the transmit queue |
| tx_pop_data | output | 32 | Last word popped from the transmit queue |
| tx_count | output | 4 | Transmit queue entry count |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_thresh | output | 1 | Transmit watermark flag |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_push | input | 1 | Push a word into the receive queue |
| rx_push_data | input | 32 | Word to push into the receive queue |
| rx_pop | input | 1 | Pop a word from the receive queue |
| rx_pop_data | output | 32 | Last word popped from the receive queue |
| rx_count | output | 4 | Receive queue entry count |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_thresh | output | 1 | Receive watermark flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| irq_tx_underflow | output | 1 | Gated transmit underflow interrupt |
| irq_rx_overflow | output | 1 | Gated receive overflow interrupt |
| irq_rx_timeout | output | 1 | Gated receive timeout interrupt |
| irq_tx_thresh | output | 1 | Gated transmit watermark interrupt |
| irq_rx_thresh | output | 1 | Gated receive watermark interrupt |

## Verification
The hardest case to reach is a queue holding more words than the short-word limit when the data length switches to a long word. At that moment the count exceeds the new usable depth, so full must assert, pushes must drop, and the two-bit watermark applies to a count of up to eight. A second hard case is a clear or reset pulse that lands in the same cycle as a push or pop on that queue.

The stimulus fills both queues in short-word mode and then changes data_len mid-stream. A long random phase mixes data-length changes with random control writes, so that clears, resets and watermark changes fall on busy cycles. A behavioural queue model checks every output after every edge.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int          CTRL_W     = 32;
    localparam int          THR_W      = 3;
    localparam logic [31:0] CTRL_RST   = 32'h2200_0000;
    localparam logic [31:0] CTRL_WMASK = 32'h7700_03BF;
    localparam logic [31:0] CTRL_PULSE = 32'h0000_0303;
    localparam int          LONG_WORD  = 16;

    // Control field positions (decoded by the queue and interrupt logic)
    localparam int TXTH_LSB  = 28;
    localparam int RXTH_LSB  = 24;
    localparam int B_TXCLR   = 9;
    localparam int B_RXCLR   = 8;
    localparam int B_TXUFIE  = 7;
    localparam int B_RXOVIE  = 5;
    localparam int B_RXTOIE  = 4;
    localparam int B_TXTHIE  = 3;
    localparam int B_RXTHIE  = 2;
    localparam int B_TXRST   = 1;
    localparam int B_RXRST   = 0;

    typedef enum logic {DIR_TX, DIR_RX} dir_e;

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic             tx_uf_ie;
        logic             rx_ov_ie;
        logic             rx_to_ie;
        logic             tx_th_ie;
        logic             rx_th_ie;
    } ctrl_t;

    typedef struct packed {
        logic clr;      // empty the queue this edge
        logic flag_clr; // also clear the sticky error flag
    } clr_t;

    function automatic ctrl_t unpack_ctrl(logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.tx_thr   = w[TXTH_LSB +: THR_W];
        c.rx_thr   = w[RXTH_LSB +: THR_W];
        c.tx_uf_ie = w[B_TXUFIE];
        c.rx_ov_ie = w[B_RXOVIE];
        c.rx_to_ie = w[B_RXTOIE];
        c.tx_th_ie = w[B_TXTHIE];
        c.rx_th_ie = w[B_RXTHIE];
        return c;
    endfunction

    function automatic logic [THR_W-1:0] eff_thr(logic [THR_W-1:0] thr, logic wide);
        return wide ? {1'b0, thr[THR_W-2:0]} : thr;
    endfunction

endpackage

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
    import spi_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] reg_q,
    output ctrl_t             cfg,
    output clr_t              tx_clr,
    output clr_t              rx_clr
);

    always_ff @(posedge clk) begin
        if (rst)        reg_q <= CTRL_RST;
        else if (wr_en) reg_q <= wr_data & CTRL_WMASK;
        else            reg_q <= reg_q & ~CTRL_PULSE;
    end

    assign cfg = unpack_ctrl(reg_q);

    // Clear actions take effect at the edge of the write itself
    always_comb begin
        tx_clr.flag_clr = wr_en & wr_data[B_TXRST];
        rx_clr.flag_clr = wr_en & wr_data[B_RXRST];
        tx_clr.clr      = wr_en & (wr_data[B_TXCLR] | wr_data[B_TXRST]);
        rx_clr.clr      = wr_en & (wr_data[B_RXCLR] | wr_data[B_RXRST]);
    end

    a_r7_pulse_self_clear: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((reg_q & CTRL_PULSE) == '0));

    a_r13_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((reg_q & ~CTRL_WMASK) == '0));

endmodule

// File: rtl/spi_fifo_chan.sv
module spi_fifo_chan
    import spi_fifo_pkg::*;
#(
    parameter int   DATA_W = 32,
    parameter int   DEPTH  = 8,
    parameter dir_e DIR    = DIR_TX
) (
    input  logic                       clk,
    input  logic                       rst,
    input  clr_t                       clr_in,
    input  logic                       wide,
    input  logic [THR_W-1:0]           thr,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          pop_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       thresh,
    output logic                       sticky
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HALF  = DEPTH / 2;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  limit, eff;
    logic              do_push, do_pop, err_ev;

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign limit   = wide ? CNT_W'(HALF) : CNT_W'(DEPTH);
    assign full    = count >= limit;
    assign empty   = count == '0;
    assign do_push = push & ~full  & ~clr_in.clr;
    assign do_pop  = pop  & ~empty & ~clr_in.clr;
    assign eff     = CNT_W'(eff_thr(thr, wide));

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_in.clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Holding register: untouched by clears
    always_ff @(posedge clk) begin
        if (rst)         pop_data <= '0;
        else if (do_pop) pop_data <= mem[rd_ptr];
    end

    generate
        if (DIR == DIR_TX) begin : g_tx
            assign thresh = count <= eff;
            assign err_ev = pop & empty & ~clr_in.clr;
            a_r4_empty_below_mark: assert property (@(posedge clk) disable iff (rst)
                empty |-> thresh);
        end else begin : g_rx
            assign thresh = count > eff;
            assign err_ev = push & full & ~clr_in.clr;
            a_r5_empty_not_above: assert property (@(posedge clk) disable iff (rst)
                empty |-> !thresh);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr_in.flag_clr) sticky <= 1'b0;
        else if (err_ev)            sticky <= 1'b1;
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    a_r3_full_drops: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr_in.clr) |=> $stable(count));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr_in.clr |=> (empty && !full));

    a_r8_clear_keeps_data: assert property (@(posedge clk) disable iff (rst)
        clr_in.clr |=> $stable(pop_data));

    a_r9_r10_error_sticks: assert property (@(posedge clk) disable iff (rst)
        (err_ev && !clr_in.flag_clr) |=> sticky);

    a_r11_flag_clears: assert property (@(posedge clk) disable iff (rst)
        clr_in.flag_clr |=> !sticky);

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr_en,
    input  logic [31:0]                cfg_wr_data,
    output logic [31:0]                cfg_rd_data,
    input  logic [5:0]                 data_len,
    input  logic                       rx_timeout,
    input  logic                       tx_push,
    input  logic [DATA_W-1:0]          tx_push_data,
    input  logic                       tx_pop,
    output logic [DATA_W-1:0]          tx_pop_data,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic                       tx_full,
    output logic                       tx_empty,
    output logic                       tx_thresh,
    output logic                       tx_underflow,
    input  logic                       rx_push,
    input  logic [DATA_W-1:0]          rx_push_data,
    input  logic                       rx_pop,
    output logic [DATA_W-1:0]          rx_pop_data,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       rx_full,
    output logic                       rx_empty,
    output logic                       rx_thresh,
    output logic                       rx_overflow,
    output logic                       irq_tx_underflow,
    output logic                       irq_rx_overflow,
    output logic                       irq_rx_timeout,
    output logic                       irq_tx_thresh,
    output logic                       irq_rx_thresh
);

    ctrl_t cfg;
    clr_t  tx_clr, rx_clr;
    logic  wide;

    assign wide = data_len > 6'(LONG_WORD);

    spi_fifo_ctrl i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .reg_q   (cfg_rd_data),
        .cfg     (cfg),
        .tx_clr  (tx_clr),
        .rx_clr  (rx_clr)
    );

    spi_fifo_chan #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DIR(DIR_TX)) i_tx (
        .clk       (clk),
        .rst       (rst),
        .clr_in    (tx_clr),
        .wide      (wide),
        .thr       (cfg.tx_thr),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty),
        .thresh    (tx_thresh),
        .sticky    (tx_underflow)
    );

    spi_fifo_chan #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DIR(DIR_RX)) i_rx (
        .clk       (clk),
        .rst       (rst),
        .clr_in    (rx_clr),
        .wide      (wide),
        .thr       (cfg.rx_thr),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty),
        .thresh    (rx_thresh),
        .sticky    (rx_overflow)
    );

    assign irq_tx_underflow = cfg.tx_uf_ie & tx_underflow;
    assign irq_rx_overflow  = cfg.rx_ov_ie & rx_overflow;
    assign irq_rx_timeout   = cfg.rx_to_ie & rx_timeout;
    assign irq_tx_thresh    = cfg.tx_th_ie & tx_thresh;
    assign irq_rx_thresh    = cfg.rx_th_ie & rx_thresh;

    a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (irq_tx_underflow |-> tx_underflow) and (irq_rx_overflow |-> rx_overflow));

endmodule

// File: tb/test_spi_fifo_pair.sv
`timescale 1ns/1ps
module test_spi_fifo_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [5:0]  data_len = 6'd8;
    logic        rx_timeout = 1'b0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [31:0] tx_push_data = '0, rx_push_data = '0;
    logic [31:0] tx_pop_data, rx_pop_data;
    logic [3:0]  tx_count, rx_count;
    logic        tx_full, tx_empty, tx_thresh, tx_underflow;
    logic        rx_full, rx_empty, rx_thresh, rx_overflow;
    logic        irq_tx_underflow, irq_rx_overflow, irq_rx_timeout, irq_tx_thresh, irq_rx_thresh;

    always #2.5 clk = ~clk;

    spi_fifo_pair i_spi_fifo_pair (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model
    logic [31:0] m_ctrl;
    logic [31:0] mtx[$];
    logic [31:0] mrx[$];
    logic [31:0] m_txd, m_rxd;
    bit          m_uf, m_of;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int eff(int thr, bit wide);
        return wide ? (thr & 3) : thr;
    endfunction

    task automatic model_step();
        int  depth, n;
        bit  wide, txc, rxc;
        wide = data_len > 16;
        depth = wide ? 4 : 8;
        if (rst) begin
            m_ctrl = 32'h2200_0000; mtx.delete(); mrx.delete();
            m_txd = 0; m_rxd = 0; m_uf = 0; m_of = 0;
            return;
        end
        txc = cfg_wr_en && (cfg_wr_data[9] || cfg_wr_data[1]);
        rxc = cfg_wr_en && (cfg_wr_data[8] || cfg_wr_data[0]);
        if (txc) begin
            mtx.delete();
            if (cfg_wr_data[1]) m_uf = 0;
        end else begin
            n = mtx.size();
            if (tx_pop && n > 0) m_txd = mtx.pop_front();
            else if (tx_pop) m_uf = 1;
            if (tx_push && n < depth) mtx.push_back(tx_push_data);
        end
        if (rxc) begin
            mrx.delete();
            if (cfg_wr_data[0]) m_of = 0;
        end else begin
            n = mrx.size();
            if (rx_pop && n > 0) m_rxd = mrx.pop_front();
            if (rx_push && n < depth) mrx.push_back(rx_push_data);
            else if (rx_push) m_of = 1;
        end
        if (cfg_wr_en) m_ctrl = cfg_wr_data & 32'h7700_03BF;
        else           m_ctrl = m_ctrl & ~32'h0000_0303;
    endtask

    task automatic compare();
        bit wide;
        int depth, tth, rth, txn, rxn;
        wide = data_len > 16;
        depth = wide ? 4 : 8;
        txn = mtx.size(); rxn = mrx.size();
        tth = eff(int'(m_ctrl[30:28]), wide);
        rth = eff(int'(m_ctrl[26:24]), wide);
        chk("R13", "ctrl", cfg_rd_data, m_ctrl);
        chk("R2", "tx_count", tx_count, txn);
        chk("R2", "rx_count", rx_count, rxn);
        chk("R3", "tx_full", tx_full, txn >= depth);
        chk("R3", "rx_full", rx_full, rxn >= depth);
        chk("R7", "tx_empty", tx_empty, txn == 0);
        chk("R7", "rx_empty", rx_empty, rxn == 0);
        chk("R4", "tx_thresh", tx_thresh, txn <= tth);
        chk("R5", "rx_thresh", rx_thresh, rxn > rth);
        chk("R2", "tx_pop_data", tx_pop_data, m_txd);
        chk("R2", "rx_pop_data", rx_pop_data, m_rxd);
        chk("R10", "tx_underflow", tx_underflow, m_uf);
        chk("R9", "rx_overflow", rx_overflow, m_of);
        chk("R12", "irq_tx_underflow", irq_tx_underflow, m_ctrl[7] & m_uf);
        chk("R12", "irq_rx_overflow", irq_rx_overflow, m_ctrl[5] & m_of);
        chk("R12", "irq_rx_timeout", irq_rx_timeout, m_ctrl[4] & rx_timeout);
        chk("R12", "irq_tx_thresh", irq_tx_thresh, m_ctrl[3] & (txn <= tth));
        chk("R12", "irq_rx_thresh", irq_rx_thresh, m_ctrl[2] & (rxn > rth));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        cfg_wr_en = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    endtask

    task automatic wr(logic [31:0] v);
        cfg_wr_en = 1; cfg_wr_data = v; tick();
    endtask

    initial begin
        rst = 1; tick(); tick();
        rst = 0;
        // R1 reset state
        chk("R1", "reset ctrl", cfg_rd_data, 32'h2200_0000);
        chk("R1", "reset tx_empty", tx_empty, 1);
        chk("R1", "reset rx_count", rx_count, 0);
        chk("R1", "reset flags", {tx_underflow, rx_overflow, tx_full, rx_full}, 0);
        // R13 reserved bits ignored
        wr(32'hFFFF_FCC0);
        chk("R13", "reserved read zero", cfg_rd_data, 32'h7700_0080);
        wr(32'h0000_00BC); // enables, thresholds 0
        // R3 narrow depth 8, extra push dropped
        data_len = 8;
        for (int i = 0; i < 10; i++) begin
            tx_push = 1; tx_push_data = 32'hA000_0000 + i;
            rx_push = 1; rx_push_data = 32'hB000_0000 + i; tick();
        end
        chk("R3", "tx depth 8", tx_count, 8);
        chk("R9", "rx overflow set", rx_overflow, 1);
        // R6: switch to long words while 8 stored: full, MSB ignored
        data_len = 32; wr(32'h6600_00BC);
        chk("R6", "rx_thresh with mark 6->2", rx_thresh, 1);
        chk("R3", "tx full long", tx_full, 1);
        for (int i = 0; i < 6; i++) begin tx_pop = 1; rx_pop = 1; tick(); end
        chk("R6", "tx_thresh count 2 mark 6->2", tx_thresh, 1);
        chk("R2", "order", tx_pop_data, 32'hA000_0005);
        // R7/R8 clear while holding data
        wr(32'h6600_02BC);
        chk("R7", "clr bit reads 1", cfg_rd_data[9], 1);
        chk("R7", "tx empty after clr", tx_empty, 1);
        chk("R8", "pop data kept", tx_pop_data, 32'hA000_0005);
        tick();
        chk("R7", "clr bit self-clears", cfg_rd_data[9], 0);
        // R10 underflow
        tx_pop = 1; tick();
        chk("R10", "underflow set", tx_underflow, 1);
        chk("R10", "pop data held", tx_pop_data, 32'hA000_0005);
        rx_timeout = 1; tick();
        chk("R12", "timeout irq", irq_rx_timeout, 1);
        rx_timeout = 0;
        // R11 reset bits clear sticky
        wr(32'h6600_00BF);
        chk("R11", "underflow cleared", tx_underflow, 0);
        chk("R11", "overflow cleared", rx_overflow, 0);
        // Random phase
        for (int c = 0; c < 6000; c++) begin
            if (($urandom % 40) == 0) data_len = 6'(8 + 8 * ($urandom % 4));
            if (($urandom % 25) == 0) begin cfg_wr_en = 1; cfg_wr_data = $urandom; end
            tx_push = $urandom % 2; tx_push_data = $urandom;
            rx_push = $urandom % 2; rx_push_data = $urandom;
            tx_pop = ($urandom % 3) == 0; rx_pop = ($urandom % 3) == 0;
            rx_timeout = $urandom % 2;
            tick();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule